// File: doc/BRIEF.md
# MDIO Command Controller

This block is a PHY management master. Software controls it through a single 32-bit command word. A write to the word while the block is idle loads the opcode, the PHY address, the register number and the write data. A second write, with the start bit set, launches a Clause 22 management frame on the MDC clock and the MDIO data line. The start bit reads back as busy for the whole frame, and the hardware clears it when the last bit has been clocked out.

For a read frame, the master releases MDIO from the turnaround onward. It samples the PHY's 16 data bits on rising MDC edges and shifts them into the low half of the same word, so the data is in place when busy drops. If the PHY leaves the second turnaround bit high, meaning it did not answer, a sticky failure bit is set. That bit is cleared when the next frame starts.

MDC is made by dividing the system clock. Each MDC half period lasts `HALF_PERIOD` system clocks, and `HALF_PERIOD` must be at least 3. A frame occupies 128 × `HALF_PERIOD` cycles, which is 25.6 µs at the defaults: far inside any millisecond-scale software timeout.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command word reads 0, MDC is low and the MDIO output enable is low.
- R2: An idle write stores the command fields, which read back as follows: bits 27:26 opcode, 25:21 PHY address, 20:16 register number, 15:0 data. Bits 31:30 always read 0, and bit 28 cannot be set by software. A write with bit 29 clear starts no frame, so MDC stays low.
- R3: An idle write with bit 29 set starts a frame using the fields in that same write. Bit 29 then reads 1 for exactly 128 × HALF_PERIOD clock cycles, after which the hardware clears it.
- R4: Every frame drives, MSB first: 32 ones, then 0 then 1, then the opcode, the PHY address and the register number. A non-read frame follows these with the turnaround 1 then 0 and the 16 data bits. MDIO changes only while MDC is low.
- R5: MDC is low while idle. During a frame each MDC high phase and each MDC low phase lasts exactly HALF_PERIOD clocks. The default of 10 gives 2.5 MHz from a 50 MHz clock.
- R6: A read frame (opcode 2'b10) holds the output enable high for bits 0–45 and low for bits 46–63. The master samples the PHY's data on rising MDC edges, MSB first, into bits 15:0. Bit 28 stays 0 when the PHY drives the second turnaround bit low.
- R7: If the second turnaround bit of a read is sampled high, bit 28 reads 1 once the frame ends.
- R8: Bit 28 reads 0 from the first cycle of a new frame.
- R9: Writes that arrive while bit 29 is 1 are ignored. They change neither the frame on the wire nor the stored fields.
- R10: A frame whose opcode is not 2'b10 (write is 2'b01) keeps the output enable high for all 64 bits, and the enable is low again once the frame is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Command word write strobe |
| regWrData | input | 32 | Command word write value |
| regRdData | output | 32 | Command word read value (busy, fail, fields, data) |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Management data driven by the master |
| mdioOe | output | 1 | Output enable for the MDIO pad |
| mdioIn | input | 1 | Management data seen at the MDIO pad |

## Verification
Write frames are run with three field patterns: mixed bits, all ones, and all zeros. Together they separate errors in field order, bit order and turnaround coding from stuck bits in the serialiser. Read frames are run with a responding PHY model that returns two distinct data words, and with no PHY at all, where the pull-up holds the line high. These cases separate correct capture and release timing from the failure-flag path. One write frame receives a conflicting command in the middle of the frame. This shows whether the busy interlock protects both the wire and the stored fields, and whether the frame length stays unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int TA_SECOND  = 47;
  localparam int DATA_FIRST = 48;
  localparam int BIT_BUSY   = 29;
  localparam int BIT_FAIL   = 28;
  localparam logic [1:0] OP_READ = 2'b10;

  // control -> datapath strobes and phase levels
  typedef struct packed {
    logic load;
    logic shift;
    logic sampleTa;
    logic sampleData;
    logic done;
    logic active;
    logic turnPhase;
  } mdioStrobes_t;

  function automatic logic [FRAME_BITS-1:0] buildFrame(input logic [27:0] f);
    logic rd;
    rd = (f[27:26] == OP_READ);
    return {32'hFFFF_FFFF, 2'b01, f[27:26], f[25:21], f[20:16],
            rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : f[15:0]};
  endfunction
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_PERIOD = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  output logic         mdc,
  output mdioStrobes_t st
);
  localparam int CNT_W = $clog2(HALF_PERIOD);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PERIOD - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t       state;
  logic [CNT_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             mdcQ;
  logic             tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitIdx <= '0;
      mdcQ   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state  <= ST_RUN;
            divCnt <= '0;
            bitIdx <= '0;
            mdcQ   <= 1'b0;
          end
        end
        default: begin
          if (divCnt == CNT_LAST) begin
            divCnt <= '0;
            if (!mdcQ) begin
              mdcQ <= 1'b1;
            end else begin
              mdcQ <= 1'b0;
              if (bitIdx == IDX_LAST) state <= ST_IDLE;
              else bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    tick          = (state == ST_RUN) && (divCnt == CNT_LAST);
    st.load       = (state == ST_IDLE) && startReq;
    st.sampleTa   = tick && !mdcQ && (bitIdx == IDX_W'(TA_SECOND));
    st.sampleData = tick && !mdcQ && (bitIdx >= IDX_W'(DATA_FIRST));
    st.shift      = tick && mdcQ && (bitIdx != IDX_LAST);
    st.done       = tick && mdcQ && (bitIdx == IDX_LAST);
    st.active     = (state == ST_RUN);
    st.turnPhase  = (state == ST_RUN) && (bitIdx >= IDX_W'(TA_FIRST));
  end

  assign mdc = mdcQ;

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !st.active |-> !mdc); // R5
  AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.load, st.shift, st.sampleTa | st.sampleData, st.done})); // R3
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  mdioStrobes_t st,
  input  logic         fieldWrEn,
  input  logic [27:0]  fieldWrData,
  input  logic         mdioIn,
  output logic [31:0]  regRdData,
  output logic         busy,
  output logic         mdioOut,
  output logic         mdioOe
);
  logic                  cmdBusy;
  logic                  cmdFail;
  logic [1:0]            cmdOp;
  logic [4:0]            cmdPhy;
  logic [4:0]            cmdRegNum;
  logic [15:0]           cmdData;
  logic                  isRead;
  logic [FRAME_BITS-1:0] frameSr;
  logic [1:0]            inSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdBusy   <= 1'b0;
      cmdFail   <= 1'b0;
      cmdOp     <= '0;
      cmdPhy    <= '0;
      cmdRegNum <= '0;
      cmdData   <= '0;
      isRead    <= 1'b0;
      frameSr   <= '0;
      inSync    <= 2'b11;
    end else begin
      inSync <= {inSync[0], mdioIn};
      if (st.load) begin
        cmdBusy   <= 1'b1;
        cmdFail   <= 1'b0;
        cmdOp     <= fieldWrData[27:26];
        cmdPhy    <= fieldWrData[25:21];
        cmdRegNum <= fieldWrData[20:16];
        cmdData   <= fieldWrData[15:0];
        isRead    <= (fieldWrData[27:26] == OP_READ);
        frameSr   <= buildFrame(fieldWrData);
      end else if (fieldWrEn && !cmdBusy) begin
        cmdOp     <= fieldWrData[27:26];
        cmdPhy    <= fieldWrData[25:21];
        cmdRegNum <= fieldWrData[20:16];
        cmdData   <= fieldWrData[15:0];
      end
      if (st.shift) frameSr <= {frameSr[FRAME_BITS-2:0], 1'b1};
      if (st.sampleTa && isRead && inSync[1]) cmdFail <= 1'b1;
      if (st.sampleData && isRead) cmdData <= {cmdData[14:0], inSync[1]};
      if (st.done) cmdBusy <= 1'b0;
    end
  end

  assign regRdData = {2'b00, cmdBusy, cmdFail, cmdOp, cmdPhy, cmdRegNum, cmdData};
  assign busy      = cmdBusy;
  assign mdioOut   = frameSr[FRAME_BITS-1];
  assign mdioOe    = st.active && !(isRead && st.turnPhase);

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    cmdBusy && !st.done |=> cmdBusy); // R3
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    st.done |=> !cmdBusy); // R3
  AST_FAIL_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    st.load |=> cmdBusy && !cmdFail); // R8
  AST_FIELDS_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    cmdBusy && !st.done |=> $stable({cmdOp, cmdPhy, cmdRegNum})); // R9
  AST_WRITE_DATA_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    cmdBusy && !isRead && !st.done |=> $stable(cmdData)); // R9
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_PERIOD = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobes_t st;
  logic         busy;
  logic         startReq;
  logic         unusedWrBits;

  assign startReq     = regWrEn && regWrData[BIT_BUSY] && !busy;
  assign unusedWrBits = ^{regWrData[31:30], regWrData[BIT_FAIL]};

  mdio_ctrl #(.HALF_PERIOD(HALF_PERIOD)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .mdc      (mdc),
    .st       (st)
  );

  mdio_dp uDp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .fieldWrEn   (regWrEn),
    .fieldWrData (regWrData[27:0]),
    .mdioIn      (mdioIn),
    .regRdData   (regRdData),
    .busy        (busy),
    .mdioOut     (mdioOut),
    .mdioOe      (mdioOe)
  );

  AST_MDIO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    mdc && $past(mdc) |-> $stable(mdioOut) && $stable(mdioOe)); // R4
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regWrData[29] && !regRdData[29] |=> regRdData[29]); // R3
endmodule

// File: tb/tb_mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_cmd_ctrl;
  localparam int HALF = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe, mdioIn;
  logic        phyDrive = 1'b0;
  logic        phyBit = 1'b1;
  int          checks = 0;
  int          fails = 0;

  always #10 clk = ~clk;
  assign mdioIn = phyDrive ? phyBit : 1'b1;

  mdio_cmd_ctrl #(.HALF_PERIOD(HALF)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [31:0] w);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = w;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  function automatic logic [31:0] fields(input logic [1:0] op, input logic [4:0] phy,
                                         input logic [4:0] rg, input logic [15:0] d);
    return {4'b0000, op, phy, rg, d};
  endfunction

  task automatic runFrame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] wdata, input bit answer,
                          input logic [15:0] phyData, input bit intrude);
    logic [63:0] expFrame;
    logic [63:0] gotBits;
    logic [63:0] gotOe;
    bit   isRd;
    bit   prevMdc;
    bit   intruded;
    int   busyCnt, runLen, periodBad, rises, falls, bitBad, oeBad;
    logic [31:0] expWord;
    isRd = (op == 2'b10);
    expFrame = {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, wdata};
    gotBits = '0; gotOe = '0;
    prevMdc = 1'b0; intruded = 1'b0;
    busyCnt = 0; runLen = 0; periodBad = 0; rises = 0; falls = 0;
    cpuWrite(fields(op, phy, rg, wdata));
    cpuWrite(fields(op, phy, rg, wdata) | 32'h2000_0000);
    check(regRdData[29] === 1'b1 && regRdData[28] === 1'b0,
          "R8 start: busy set and fail clear", {62'd0, regRdData[29:28]}, 64'h2);
    while (regRdData[29] === 1'b1 && busyCnt < 4000) begin
      busyCnt++;
      if (intrude && falls == 10 && !intruded) begin
        regWrEn = 1'b1;
        regWrData = 32'h2000_0000 | fields(~op, ~phy, ~rg, ~wdata);
        intruded = 1'b1;
      end else begin
        regWrEn = 1'b0;
      end
      if (mdc !== prevMdc) begin
        if (runLen != HALF) periodBad++;
        runLen = 1;
      end else begin
        runLen++;
      end
      if (mdc && !prevMdc && rises < 64) begin
        gotBits[63-rises] = mdioOut;
        gotOe[63-rises] = mdioOe;
        rises++;
      end
      if (!mdc && prevMdc) begin
        falls++;
        if (answer && falls == 47) begin phyDrive = 1'b1; phyBit = 1'b0; end
        if (answer && falls >= 48 && falls <= 63) phyBit = phyData[63-falls];
      end
      prevMdc = mdc;
      @(negedge clk);
    end
    regWrEn = 1'b0;
    phyDrive = 1'b0; phyBit = 1'b1;
    check(busyCnt == 128*HALF, "R3 busy duration", busyCnt, 128*HALF);
    check(periodBad == 0 && rises == 64, "R5 mdc half periods", periodBad, 0);
    bitBad = 0; oeBad = 0;
    for (int i = 0; i < 64; i++) begin
      if (!(isRd && i >= 46) && gotBits[63-i] !== expFrame[63-i]) bitBad++;
      if (gotOe[63-i] !== !(isRd && i >= 46)) oeBad++;
    end
    if (isRd) begin
      check(bitBad == 0, "R6 read frame header bits", gotBits[63:18], expFrame[63:18]);
      check(oeBad == 0, "R6 output enable released from turnaround", gotOe, 64'hFFFF_FFFF_FFFC_0000);
    end else begin
      check(bitBad == 0, "R4 write frame bits", gotBits, expFrame);
      check(oeBad == 0, "R10 output enable across write frame", gotOe, 64'hFFFF_FFFF_FFFF_FFFF);
    end
    check(mdc === 1'b0 && mdioOe === 1'b0, "R10 idle after frame: mdc and enable low",
          {mdc, mdioOe}, 2'b00);
    expWord = fields(op, phy, rg, isRd ? (answer ? phyData : 16'hFFFF) : wdata);
    if (isRd && !answer) expWord[28] = 1'b1;
    if (isRd && answer)
      check(regRdData === expWord, "R6 read data and clear fail", regRdData, expWord);
    else if (isRd)
      check(regRdData === expWord, "R7 no answer sets fail", regRdData, expWord);
    else if (intrude)
      check(regRdData === expWord, "R9 fields untouched by busy write", regRdData, expWord);
    else
      check(regRdData === expWord, "R4 final word after write", regRdData, expWord);
    if (intrude)
      check(bitBad == 0 && intruded, "R9 frame unaffected by busy write", bitBad, 0);
  endtask

  task automatic testReset();
    check(regRdData === 32'h0, "R1 reset word", regRdData, 0);
    check(mdc === 1'b0 && mdioOe === 1'b0, "R1 reset mdc/enable", {mdc, mdioOe}, 0);
  endtask

  task automatic testFieldWrite();
    int highs;
    logic [31:0] exp;
    exp = fields(2'b01, 5'h15, 5'h0A, 16'hBEEF);
    cpuWrite(32'hD000_0000 | exp);
    check(regRdData === exp, "R2 field readback, reserved and fail bits zero", regRdData, exp);
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mdc !== 1'b0) highs++;
    end
    check(highs == 0, "R2 no frame without start bit", highs, 0);
    check(mdioOe === 1'b0 && regRdData[29] === 1'b0, "R5 mdc idle, not busy",
          {mdioOe, regRdData[29]}, 0);
  endtask

  task automatic testWriteMixed();    runFrame(2'b01, 5'h11, 5'h04, 16'hA5C3, 0, 16'h0, 0); endtask
  task automatic testWriteOnes();     runFrame(2'b01, 5'h1F, 5'h1F, 16'hFFFF, 0, 16'h0, 0); endtask
  task automatic testWriteZeros();    runFrame(2'b01, 5'h00, 5'h00, 16'h0000, 0, 16'h0, 0); endtask
  task automatic testReadAnswer();    runFrame(2'b10, 5'h03, 5'h02, 16'h0000, 1, 16'h3C5A, 0); endtask
  task automatic testReadEdge();      runFrame(2'b10, 5'h1F, 5'h1F, 16'h0000, 1, 16'h8001, 0); endtask
  task automatic testReadNoAnswer();  runFrame(2'b10, 5'h07, 5'h01, 16'h0000, 0, 16'h0, 0); endtask
  task automatic testFailClears();    runFrame(2'b01, 5'h09, 5'h12, 16'h1234, 0, 16'h0, 0); endtask
  task automatic testBusyWrite();     runFrame(2'b01, 5'h0C, 5'h19, 16'h5A0F, 0, 16'h0, 1); endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFieldWrite();
    testWriteMixed();
    testWriteOnes();
    testWriteZeros();
    testReadAnswer();
    testReadEdge();
    testReadNoAnswer();
    testFailClears();
    testBusyWrite();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule